// File: doc/BRIEF.md
# Adaptive DRAM Bank Command Sequencer

This block drives one DRAM bank. It accepts one memory transaction at a time. A transaction carries a row, a column and a read/write flag. The block turns it into the command sequence that the current row-buffer state calls for:

- If the requested row is already open, only a column access is needed.
- If the bank is idle, an activate must come first.
- If a different row is open, that row is precharged away before the activate.

Each gap between commands is timed by a counter loaded from a programmable latency. A one-cycle completion pulse marks the end of the column latency.

After the column access, the bank either keeps the row open or closes it with an auto-precharge. Which one depends on a page policy selected at run time:

- Open page always keeps the row.
- Close page always releases it.
- The adaptive mode tracks a saturating locality score and keeps the row only while the score is at or above a programmable threshold.

A controller above this block issues transactions through a valid/ready handshake and reads the row-buffer state from dedicated outputs.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1, `bank_open` is 0, and `cmd_valid` and `done` are 0.
- R2: A request to the open row (class code 0) issues a single column command in the cycle after acceptance, and `done` rises exactly t_cl cycles after that command.
- R3: A request to an idle bank (class code 1) issues an activate, then a column command t_rcd cycles later, then `done` t_cl cycles after the column command.
- R4: A request that hits a different open row (class code 2) issues precharge, activate after t_rp cycles, and the column command after a further t_rcd cycles. Completion time therefore orders open-row < idle < different-row.
- R5: A latency input of 0 behaves as a latency of 1 cycle.
- R6: In open-page mode (`page_mode` = 0) the column command has `cmd_autopre` = 0. Afterwards `bank_open` is 1 and `open_row` equals the accessed row, and `req_ready` returns in the same cycle as `done`.
- R7: In close-page mode (`page_mode` = 1 or 3) the column command has `cmd_autopre` = 1 and `bank_open` is 0 afterwards. `req_ready` returns t_rp cycles after `done`.
- R8: In adaptive mode (`page_mode` = 2) a score of LOC_W bits is updated on every accepted request:
  - It increments, saturating at its maximum, when the row equals the previous accepted row.
  - Otherwise it decrements, saturating at 0; there is no previous row after reset.
  - The score starts at 0 after reset.
  - The access keeps its row open iff the updated score is >= `loc_thresh`.
- R9: Requests are accepted only while `req_ready` is 1. A `req_valid` presented while busy is ignored: it issues no command and does not change the open row.
- R10: `done` is a one-cycle pulse. `done_class` gives the access class: 0 open-row, 1 idle, 2 different-row.
- R11: `cmd_kind` encodes 0 none, 1 activate, 2 read, 3 write, 4 precharge. A write request issues 3 and a read issues 2.
- R12: An activate carries the request row on `cmd_row`. A column command carries the request column on `cmd_col` and the row on `cmd_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_mode | input | 2 | Page policy: 0 open, 1 close, 2 adaptive, 3 close |
| loc_thresh | input | LOC_W | Adaptive keep-open threshold |
| lat_rp | input | TIM_W | Precharge-to-activate latency in cycles |
| lat_rcd | input | TIM_W | Activate-to-column latency in cycles |
| lat_cl | input | TIM_W | Column-to-completion latency in cycles |
| req_valid | input | 1 | Transaction present |
| req_ready | output | 1 | Sequencer idle, can accept |
| req_row | input | ROW_W | Transaction row |
| req_col | input | COL_W | Transaction column |
| req_write | input | 1 | 1 write, 0 read |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_kind | output | 3 | Command code |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| cmd_autopre | output | 1 | Column command closes the row |
| done | output | 1 | Transaction complete pulse |
| done_class | output | 2 | Class of the completed access |
| bank_open | output | 1 | A row is held open |
| open_row | output | ROW_W | Currently open row |

## Verification
The bench builds the sequencer with ROW_W=14, COL_W=10, TIM_W=6, LOC_W=3 and the adaptive variant enabled. The 3-bit score lets a short run of repeated rows climb past a threshold of 2 and later drop below it. This shows the adaptive mode switching both ways. Six-bit latency fields allow distinct gaps of several cycles, so a misplaced command is visible in time, and zero values exercise the clamp to one cycle.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

   typedef enum logic [2:0] {
      CK_NONE = 3'd0,
      CK_ACT  = 3'd1,
      CK_RD   = 3'd2,
      CK_WR   = 3'd3,
      CK_PRE  = 3'd4
   } cmd_kind_e;

   typedef enum logic [1:0] {
      AC_HIT   = 2'd0,
      AC_IDLE  = 2'd1,
      AC_CONFL = 2'd2
   } acc_class_e;

   typedef enum logic [1:0] {
      PG_OPEN  = 2'd0,
      PG_CLOSE = 2'd1,
      PG_ADAPT = 2'd2,
      PG_SHUT  = 2'd3
   } page_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_ACT  = 3'd2,
      ST_CAS  = 3'd3,
      ST_REC  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/bank_lat_timer.sv
module bank_lat_timer #(
   parameter int TIM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TIM_W-1:0] load_val,
   output logic             expire
);
   localparam logic [TIM_W-1:0] ONE = TIM_W'(1);

   logic [TIM_W-1:0] cnt;
   logic [TIM_W-1:0] eff_val;

   // zero latency is clamped to a single cycle
   assign eff_val = (load_val == '0) ? ONE : load_val;
   assign expire  = (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= eff_val;
      end else if (cnt != '0) begin
         cnt <= cnt - ONE;
      end
   end
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
   parameter int ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] cmp_row,
   input  logic             open_set,
   input  logic [ROW_W-1:0] open_row_in,
   input  logic             close_now,
   input  logic             note_en,
   output logic             bank_open,
   output logic [ROW_W-1:0] open_row,
   output logic             row_hit,
   output logic             last_match
);
   logic             last_vld;
   logic [ROW_W-1:0] last_row;

   assign row_hit    = bank_open && (open_row == cmp_row);
   assign last_match = last_vld && (last_row == cmp_row);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_open <= 1'b0;
         open_row  <= '0;
      end else if (open_set) begin
         bank_open <= 1'b1;
         open_row  <= open_row_in;
      end else if (close_now) begin
         bank_open <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_vld <= 1'b0;
         last_row <= '0;
      end else if (note_en) begin
         last_vld <= 1'b1;
         last_row <= cmp_row;
      end
   end
endmodule

// File: rtl/bank_page_policy.sv
module bank_page_policy
   import bank_seq_pkg::*;
#(
   parameter int LOC_W     = 3,
   parameter bit HYBRID_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       page_mode,
   input  logic [LOC_W-1:0] loc_thresh,
   input  logic             update_en,
   input  logic             locality_hit,
   output logic             keep_open
);
   localparam logic [LOC_W-1:0] SCORE_MAX = {LOC_W{1'b1}};
   localparam logic [LOC_W-1:0] SCORE_ONE = LOC_W'(1);

   logic adapt_keep;

   generate
      if (HYBRID_EN) begin : g_adapt
         logic [LOC_W-1:0] score;
         logic [LOC_W-1:0] score_nxt;

         always_comb begin
            if (locality_hit) begin
               score_nxt = (score == SCORE_MAX) ? score : score + SCORE_ONE;
            end else begin
               score_nxt = (score == '0) ? score : score - SCORE_ONE;
            end
         end

         assign adapt_keep = (score_nxt >= loc_thresh);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               score <= '0;
            end else if (update_en) begin
               score <= score_nxt;
            end
         end
      end else begin : g_fixed
         // without the score, adaptive mode falls back to releasing rows
         assign adapt_keep = 1'b0;
      end
   endgenerate

   always_comb begin
      case (page_mode_e'(page_mode))
         PG_OPEN:  keep_open = 1'b1;
         PG_ADAPT: keep_open = adapt_keep;
         default:  keep_open = 1'b0;
      endcase
   end
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
   import bank_seq_pkg::*;
#(
   parameter int ROW_W     = 14,
   parameter int COL_W     = 10,
   parameter int TIM_W     = 6,
   parameter int LOC_W     = 3,
   parameter bit HYBRID_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       page_mode,
   input  logic [LOC_W-1:0] loc_thresh,
   input  logic [TIM_W-1:0] lat_rp,
   input  logic [TIM_W-1:0] lat_rcd,
   input  logic [TIM_W-1:0] lat_cl,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic             req_write,
   output logic             cmd_valid,
   output logic [2:0]       cmd_kind,
   output logic [ROW_W-1:0] cmd_row,
   output logic [COL_W-1:0] cmd_col,
   output logic             cmd_autopre,
   output logic             done,
   output logic [1:0]       done_class,
   output logic             bank_open,
   output logic [ROW_W-1:0] open_row
);
   generate
      if (ROW_W < 1 || ROW_W > 32) begin : g_bad_row
         $error("bank_cmd_seq: ROW_W out of range");
      end
      if (COL_W < 1 || COL_W > 32) begin : g_bad_col
         $error("bank_cmd_seq: COL_W out of range");
      end
      if (TIM_W < 2 || TIM_W > 16) begin : g_bad_tim
         $error("bank_cmd_seq: TIM_W out of range");
      end
      if (LOC_W < 1 || LOC_W > 8) begin : g_bad_loc
         $error("bank_cmd_seq: LOC_W out of range");
      end
   endgenerate

   seq_state_e       st, st_nxt;
   logic [ROW_W-1:0] q_row;
   logic [COL_W-1:0] q_col;
   logic             q_wr;
   logic             q_keep;
   logic [1:0]       q_cls;

   logic             accept;
   logic             tim_load;
   logic [TIM_W-1:0] tim_val;
   logic             tim_exp;

   logic             trk_open_set;
   logic             trk_close;
   logic             trk_note;
   logic             trk_hit;
   logic             trk_last;
   logic [ROW_W-1:0] trk_cmp_row;
   logic             pol_keep;

   logic             n_cmd_v;
   cmd_kind_e        n_cmd_k;
   logic [ROW_W-1:0] n_cmd_row;
   logic [COL_W-1:0] n_cmd_col;
   logic             n_cmd_ap;
   logic             n_done;

   assign req_ready   = (st == ST_IDLE);
   assign accept      = req_ready && req_valid;
   assign trk_cmp_row = (st == ST_IDLE) ? req_row : q_row;

   bank_lat_timer #(.TIM_W(TIM_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tim_load),
      .load_val (tim_val),
      .expire   (tim_exp)
   );

   bank_row_tracker #(.ROW_W(ROW_W)) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmp_row     (trk_cmp_row),
      .open_set    (trk_open_set),
      .open_row_in (trk_cmp_row),
      .close_now   (trk_close),
      .note_en     (trk_note),
      .bank_open   (bank_open),
      .open_row    (open_row),
      .row_hit     (trk_hit),
      .last_match  (trk_last)
   );

   bank_page_policy #(.LOC_W(LOC_W), .HYBRID_EN(HYBRID_EN)) u_policy (
      .clk          (clk),
      .rst_n        (rst_n),
      .page_mode    (page_mode),
      .loc_thresh   (loc_thresh),
      .update_en    (accept),
      .locality_hit (trk_last),
      .keep_open    (pol_keep)
   );

   function automatic cmd_kind_e col_kind(input logic wr);
      return wr ? CK_WR : CK_RD;
   endfunction

   always_comb begin
      st_nxt       = st;
      tim_load     = 1'b0;
      tim_val      = lat_cl;
      trk_open_set = 1'b0;
      trk_close    = 1'b0;
      trk_note     = 1'b0;
      n_cmd_v      = 1'b0;
      n_cmd_k      = CK_NONE;
      n_cmd_row    = q_row;
      n_cmd_col    = q_col;
      n_cmd_ap     = 1'b0;
      n_done       = 1'b0;
      case (st)
         ST_IDLE: begin
            n_cmd_row = req_row;
            n_cmd_col = req_col;
            if (accept) begin
               trk_note = 1'b1;
               n_cmd_v  = 1'b1;
               tim_load = 1'b1;
               if (trk_hit) begin
                  n_cmd_k   = col_kind(req_write);
                  n_cmd_ap  = !pol_keep;
                  trk_close = !pol_keep;
                  tim_val   = lat_cl;
                  st_nxt    = ST_CAS;
               end else if (!bank_open) begin
                  n_cmd_k      = CK_ACT;
                  trk_open_set = 1'b1;
                  tim_val      = lat_rcd;
                  st_nxt       = ST_ACT;
               end else begin
                  n_cmd_k   = CK_PRE;
                  trk_close = 1'b1;
                  tim_val   = lat_rp;
                  st_nxt    = ST_PRE;
               end
            end
         end
         ST_PRE: begin
            if (tim_exp) begin
               n_cmd_v      = 1'b1;
               n_cmd_k      = CK_ACT;
               trk_open_set = 1'b1;
               tim_load     = 1'b1;
               tim_val      = lat_rcd;
               st_nxt       = ST_ACT;
            end
         end
         ST_ACT: begin
            if (tim_exp) begin
               n_cmd_v   = 1'b1;
               n_cmd_k   = col_kind(q_wr);
               n_cmd_ap  = !q_keep;
               trk_close = !q_keep;
               tim_load  = 1'b1;
               tim_val   = lat_cl;
               st_nxt    = ST_CAS;
            end
         end
         ST_CAS: begin
            if (tim_exp) begin
               n_done = 1'b1;
               if (!q_keep) begin
                  tim_load = 1'b1;
                  tim_val  = lat_rp;
                  st_nxt   = ST_REC;
               end else begin
                  st_nxt = ST_IDLE;
               end
            end
         end
         ST_REC: begin
            if (tim_exp) begin
               st_nxt = ST_IDLE;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         q_row  <= '0;
         q_col  <= '0;
         q_wr   <= 1'b0;
         q_keep <= 1'b1;
         q_cls  <= AC_HIT;
      end else begin
         st <= st_nxt;
         if (accept) begin
            q_row  <= req_row;
            q_col  <= req_col;
            q_wr   <= req_write;
            q_keep <= pol_keep;
            q_cls  <= trk_hit ? AC_HIT : (bank_open ? AC_CONFL : AC_IDLE);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid   <= 1'b0;
         cmd_kind    <= CK_NONE;
         cmd_row     <= '0;
         cmd_col     <= '0;
         cmd_autopre <= 1'b0;
         done        <= 1'b0;
         done_class  <= AC_HIT;
      end else begin
         cmd_valid   <= n_cmd_v;
         cmd_kind    <= n_cmd_v ? n_cmd_k : CK_NONE;
         cmd_row     <= n_cmd_row;
         cmd_col     <= n_cmd_col;
         cmd_autopre <= n_cmd_v && n_cmd_ap;
         done        <= n_done;
         if (n_done) begin
            done_class <= q_cls;
         end
      end
   end
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk
   import bank_seq_pkg::*;
#(
   parameter int ROW_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             cmd_valid,
   input logic [2:0]       cmd_kind,
   input logic [ROW_W-1:0] cmd_row,
   input logic             cmd_autopre,
   input logic             done,
   input logic             bank_open,
   input logic [ROW_W-1:0] open_row
);
   logic is_col;
   assign is_col = cmd_valid && (cmd_kind == CK_RD || cmd_kind == CK_WR);

   // R9
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !req_ready);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == CK_ACT) |-> (bank_open && open_row == cmd_row));

   // R4
   pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == CK_PRE) |-> (!bank_open && $past(bank_open)));

   // R2
   col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> $past(bank_open));

   // R7
   autopre_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_col && cmd_autopre) |-> !bank_open);

   // R6
   keep_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_col && !cmd_autopre) |-> (bank_open && open_row == cmd_row));

   // R3
   done_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid);
endmodule

bind bank_cmd_seq bank_cmd_seq_chk #(.ROW_W(ROW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .cmd_valid   (cmd_valid),
   .cmd_kind    (cmd_kind),
   .cmd_row     (cmd_row),
   .cmd_autopre (cmd_autopre),
   .done        (done),
   .bank_open   (bank_open),
   .open_row    (open_row)
);

// File: tb/bank_cmd_seq_bench.sv
module bank_cmd_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 14;
   localparam int COL_W = 10;
   localparam int TIM_W = 6;
   localparam int LOC_W = 3;
   localparam int K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       page_mode = 2'd0;
   logic [LOC_W-1:0] loc_thresh = '0;
   logic [TIM_W-1:0] lat_rp = 6'd3, lat_rcd = 6'd4, lat_cl = 6'd2;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic             req_write = 1'b0;
   logic             cmd_valid;
   logic [2:0]       cmd_kind;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;
   logic             cmd_autopre;
   logic             done;
   logic [1:0]       done_class;
   logic             bank_open;
   logic [ROW_W-1:0] open_row;

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   int last_done_at = 0;

   // reference model of bank and score
   bit               m_open;
   logic [ROW_W-1:0] m_row;
   int               m_score;
   bit               m_lv;
   logic [ROW_W-1:0] m_lr;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TIM_W(TIM_W), .LOC_W(LOC_W),
                  .HYBRID_EN(1'b1)) u_bank_cmd_seq (
      .clk(clk), .rst_n(rst_n), .page_mode(page_mode), .loc_thresh(loc_thresh),
      .lat_rp(lat_rp), .lat_rcd(lat_rcd), .lat_cl(lat_cl),
      .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
      .req_col(req_col), .req_write(req_write), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .cmd_autopre(cmd_autopre), .done(done), .done_class(done_class),
      .bank_open(bank_open), .open_row(open_row));

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int eff(input logic [TIM_W-1:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   task automatic do_reset();
      req_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_open = 0; m_row = '0; m_score = 0; m_lv = 0; m_lr = '0;
      @(negedge clk);
   endtask

   // one transaction; hold>0 keeps req_valid high with another row while busy
   task automatic run_req(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                          input bit wr, input int hold, input string tag);
      int cls, n_cmd, done_at, ready_at, dcls;
      int k_at[4];
      int k_kind[4];
      int k_ap[4];
      int k_row[4];
      int k_col[4];
      bit keep, loc;
      int rp, rcd, cl, exp_done, exp_ready;
      rp = eff(lat_rp); rcd = eff(lat_rcd); cl = eff(lat_cl);
      cls = (m_open && m_row == row) ? 0 : (m_open ? 2 : 1);
      loc = m_lv && (m_lr == row);
      if (loc) m_score = (m_score == (1 << LOC_W) - 1) ? m_score : m_score + 1;
      else     m_score = (m_score == 0) ? 0 : m_score - 1;
      m_lv = 1; m_lr = row;
      case (page_mode)
         2'd0: keep = 1;
         2'd2: keep = (m_score >= int'(loc_thresh));
         default: keep = 0;
      endcase
      exp_done  = (cls == 0) ? cl : (cls == 1) ? rcd + cl : rp + rcd + cl;
      exp_ready = exp_done + (keep ? 0 : rp);

      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_row = row; req_col = col; req_write = wr;
      @(negedge clk);
      n_cmd = 0; done_at = -1; ready_at = -1; dcls = -1;
      for (int i = 0; i < 400; i++) begin
         if (hold > 0 && i == 0) req_row = row ^ 14'h2A5;
         if (i >= hold) req_valid = 1'b0;
         if (cmd_valid) begin
            if (n_cmd < 4) begin
               k_at[n_cmd] = i; k_kind[n_cmd] = int'(cmd_kind);
               k_ap[n_cmd] = int'(cmd_autopre); k_row[n_cmd] = int'(cmd_row);
               k_col[n_cmd] = int'(cmd_col);
            end
            n_cmd++;
         end
         if (done) begin done_at = i; dcls = int'(done_class); end
         if (req_ready) begin ready_at = i; break; end
         @(negedge clk);
      end
      req_valid = 1'b0;

      check(dcls == cls, "R10", "done class", dcls, cls);
      check(done_at == exp_done, tag, "done latency", done_at, exp_done);
      check(ready_at == exp_ready, tag, "ready return", ready_at, exp_ready);
      check(n_cmd == cls + 1, "R9", "command count", n_cmd, cls + 1);
      if (n_cmd == cls + 1) begin
         if (cls == 2) begin
            check(k_kind[0] == K_PRE && k_at[0] == 0, "R4", "precharge first", k_kind[0], K_PRE);
            check(k_kind[1] == K_ACT && k_at[1] == rp, "R4", "activate after tRP", k_at[1], rp);
         end
         if (cls == 1)
            check(k_kind[0] == K_ACT && k_at[0] == 0, "R3", "activate first", k_kind[0], K_ACT);
         if (cls >= 1)
            check(k_row[cls - 1] == int'(row), "R12", "activate row", k_row[cls - 1], int'(row));
         check(k_kind[cls] == (wr ? K_WR : K_RD), "R11", "column kind", k_kind[cls], wr ? K_WR : K_RD);
         check(k_at[cls] == exp_done - cl, tag, "column time", k_at[cls], exp_done - cl);
         check(k_col[cls] == int'(col) && k_row[cls] == int'(row), "R12", "column addr",
               k_col[cls], int'(col));
         check(k_ap[cls] == int'(!keep), tag, "autopre flag", k_ap[cls], int'(!keep));
      end
      // nothing more happens while idle
      for (int j = 0; j < 2; j++) begin
         @(negedge clk);
         check(!cmd_valid, "R9", "idle bus", int'(cmd_valid), 0);
      end
      check(bank_open == keep, tag, "bank open after", int'(bank_open), int'(keep));
      if (keep) check(open_row == row, tag, "open row after", int'(open_row), int'(row));
      m_open = keep; m_row = row;
      last_done_at = done_at;
   endtask

   task automatic t_reset();
      do_reset();
      check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      check(bank_open == 1'b0, "R1", "closed after reset", int'(bank_open), 0);
      check(!cmd_valid && !done, "R1", "quiet after reset", int'(cmd_valid), 0);
   endtask

   task automatic t_open_page();
      int l_idle, l_hit, l_conf;
      page_mode = 2'd0; lat_rp = 6'd3; lat_rcd = 6'd4; lat_cl = 6'd2;
      run_req(14'd10, 10'd33, 1'b0, 0, "R3");  l_idle = last_done_at;
      run_req(14'd10, 10'd7,  1'b1, 0, "R2");  l_hit = last_done_at;
      run_req(14'd20, 10'd99, 1'b0, 0, "R6");  l_conf = last_done_at;
      check(l_hit < l_idle && l_idle < l_conf, "R4", "latency order", l_conf, l_idle);
   endtask

   task automatic t_busy_ignored();
      run_req(14'd20, 10'd5, 1'b1, 2, "R9");
      run_req(14'd100, 10'd1, 1'b0, 3, "R9");
   endtask

   task automatic t_close_page();
      page_mode = 2'd1;
      run_req(14'd100, 10'd2, 1'b0, 0, "R7");
      run_req(14'd100, 10'd3, 1'b1, 0, "R7");
      page_mode = 2'd3;
      run_req(14'd55, 10'd4, 1'b0, 0, "R7");
   endtask

   task automatic t_zero_lat();
      page_mode = 2'd0; lat_rp = 6'd0; lat_rcd = 6'd0; lat_cl = 6'd0;
      run_req(14'd1, 10'd8, 1'b0, 0, "R5");
      run_req(14'd2, 10'd9, 1'b1, 0, "R5");
      run_req(14'd2, 10'd9, 1'b0, 0, "R5");
      lat_rp = 6'd2; lat_rcd = 6'd3; lat_cl = 6'd4;
   endtask

   task automatic t_adaptive();
      do_reset();
      page_mode = 2'd2; loc_thresh = 3'd2;
      run_req(14'd5, 10'd0, 1'b0, 0, "R8");
      run_req(14'd5, 10'd1, 1'b0, 0, "R8");
      run_req(14'd5, 10'd2, 1'b0, 0, "R8");
      run_req(14'd5, 10'd3, 1'b1, 0, "R8");
      run_req(14'd9, 10'd4, 1'b0, 0, "R8");
      run_req(14'd7, 10'd5, 1'b0, 0, "R8");
      run_req(14'd7, 10'd6, 1'b0, 0, "R8");
   endtask

   initial begin
      t_reset();
      t_open_page();
      t_busy_ignored();
      t_close_page();
      t_zero_lat();
      t_adaptive();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule